// File: doc/BRIEF.md
# PLL Lock Detector

This block decides whether a phase-locked loop has settled. It works from the up and down pulses of the phase-frequency detector, sampled on a fast clock. In each reference period it counts the fast-clock cycles in which exactly one of the two pulses is high. At the end of the period, marked by a one-cycle reference strobe, that count is compared against a selectable mismatch limit. The limit is a narrow window of about 15 ns or a wide one of about 30 ns, each given as a cycle count.

A period within the limit is clean. The lock flag is raised once a selectable number of consecutive reference periods have all been clean. A single period over the limit drops the flag and starts the count again. A PLL restart pulse or reset does the same. One status bit carries either the lock flag or an external low-signal-strength flag, chosen by a select input.

Top module: `pll_lock_monitor`

## Requirements
- R1: A fast-clock cycle adds to the period's mismatch count only when exactly one of `up_i` and `dn_i` is high. Cycles with both high or both low add nothing.
- R2: A period is clean when its mismatch count, including the strobe cycle, is at most the limit. The limit is NARROW_CYC when `win_sel` is 0 and WIDE_CYC when `win_sel` is 1.
- R3: `hold_sel` sets the number of consecutive clean periods needed for lock: 2'b00 gives 2, 2'b01 gives 4, 2'b10 gives 8 and 2'b11 gives 16.
- R4: `lock_o` rises in the cycle after the strobe that ends the required clean period. It changes at no other time except through restart or reset.
- R5: A period that exceeds the limit clears `lock_o` in the cycle after its strobe and zeroes the consecutive-period count.
- R6: A one-cycle `restart` pulse clears `lock_o`, the consecutive-period count and the running mismatch count from the next cycle on.
- R7: The mismatch count restarts at zero after every strobe, so mismatch in one period never adds to the next.
- R8: `status_o` equals `lock_o` when `stat_sel` is 0 and equals `low_sig_i` when `stat_sel` is 1.
- R9: While `rst` is high, `lock_o` is 0 from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| restart | input | 1 | PLL restart pulse; clears the lock qualification |
| up_i | input | 1 | Phase detector up pulse |
| dn_i | input | 1 | Phase detector down pulse |
| ref_tick | input | 1 | One-cycle strobe in the last cycle of each reference period |
| hold_sel | input | 2 | Required clean-period count select |
| win_sel | input | 1 | Mismatch window select (0 narrow, 1 wide) |
| stat_sel | input | 1 | Status bit source (0 lock, 1 low-signal flag) |
| low_sig_i | input | 1 | External low-signal-strength flag |
| lock_o | output | 1 | Lock flag |
| status_o | output | 1 | Shared status bit |

## Verification
Periods are driven with up-only, down-only and overlapping up/down pulses. This separates a one-sided mismatch from equal pulses that cost nothing. Mismatch counts are placed exactly at the limit and one above it for both windows, which pins down the comparison boundary. Runs of clean periods are checked one period at a time for every hold setting, so lock is seen to rise on the right strobe and no earlier. Bad periods and restarts are inserted into locked runs, and mismatch is split across adjacent periods, to show that the count is cleared and not carried over.

// File: rtl/lock_pkg.sv
package lock_pkg;

    localparam int HOLD_SEL_W = 2;

    typedef struct packed {
        logic valid;
        logic clean;
    } period_verdict_t;

    function automatic int hold_target(input logic [HOLD_SEL_W-1:0] sel);
        return 2 << sel;
    endfunction

    function automatic int window_limit(input logic wide, input int narrow_cyc, input int wide_cyc);
        return wide ? wide_cyc : narrow_cyc;
    endfunction

endpackage

// File: rtl/mismatch_meter.sv
module mismatch_meter
    import lock_pkg::*;
#(
    parameter int MIS_W      = 8,
    parameter int NARROW_CYC = 2,
    parameter int WIDE_CYC   = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            restart,
    input  logic            up_i,
    input  logic            dn_i,
    input  logic            ref_tick,
    input  logic            win_sel,
    output period_verdict_t verdict
);

    localparam logic [MIS_W-1:0] ACC_MAX = '1;

    logic [MIS_W-1:0] acc_q;
    logic             one_sided;
    logic [MIS_W:0]   total;
    logic [MIS_W:0]   limit;

    assign one_sided = up_i ^ dn_i;
    assign total     = {1'b0, acc_q} + {{MIS_W{1'b0}}, one_sided};
    assign limit     = (MIS_W+1)'(window_limit(win_sel, NARROW_CYC, WIDE_CYC));

    always_ff @(posedge clk) begin
        if (rst || restart || ref_tick) begin
            acc_q <= '0;
        end else if (one_sided && acc_q != ACC_MAX) begin
            acc_q <= acc_q + 1'b1;
        end
    end

    always_comb begin
        verdict.valid = ref_tick && !restart;
        verdict.clean = (total <= limit);
    end

endmodule

// File: rtl/hold_qualifier.sv
module hold_qualifier
    import lock_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  restart,
    input  period_verdict_t       verdict,
    input  logic [HOLD_SEL_W-1:0] hold_sel,
    output logic                  lock_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] run_q;
    logic [CNT_W-1:0] run_next;
    logic [CNT_W-1:0] need;

    assign need     = CNT_W'(hold_target(hold_sel));
    assign run_next = (run_q == CNT_MAX) ? run_q : run_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            run_q  <= '0;
            lock_o <= 1'b0;
        end else if (verdict.valid) begin
            if (verdict.clean) begin
                run_q  <= run_next;
                lock_o <= (run_next >= need);
            end else begin
                run_q  <= '0;
                lock_o <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/status_mux.sv
module status_mux (
    input  logic sel,
    input  logic lock_i,
    input  logic low_sig_i,
    output logic status_o
);

    always_comb begin
        status_o = sel ? low_sig_i : lock_i;
    end

endmodule

// File: rtl/pll_lock_monitor.sv
module pll_lock_monitor
    import lock_pkg::*;
#(
    parameter int MIS_W      = 8,
    parameter int NARROW_CYC = 2,
    parameter int WIDE_CYC   = 4,
    parameter int CNT_W      = 5
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       restart,
    input  logic       up_i,
    input  logic       dn_i,
    input  logic       ref_tick,
    input  logic [1:0] hold_sel,
    input  logic       win_sel,
    input  logic       stat_sel,
    input  logic       low_sig_i,
    output logic       lock_o,
    output logic       status_o
);

    period_verdict_t verdict;

    mismatch_meter #(
        .MIS_W(MIS_W), .NARROW_CYC(NARROW_CYC), .WIDE_CYC(WIDE_CYC)
    ) u_meter (
        .clk(clk), .rst(rst), .restart(restart), .up_i(up_i), .dn_i(dn_i),
        .ref_tick(ref_tick), .win_sel(win_sel), .verdict(verdict)
    );

    hold_qualifier #(.CNT_W(CNT_W)) u_hold (
        .clk(clk), .rst(rst), .restart(restart), .verdict(verdict),
        .hold_sel(hold_sel), .lock_o(lock_o)
    );

    status_mux u_stat (
        .sel(stat_sel), .lock_i(lock_o), .low_sig_i(low_sig_i), .status_o(status_o)
    );

endmodule

// File: rtl/lock_checker.sv
module lock_checker (
    input logic clk,
    input logic rst,
    input logic restart,
    input logic ref_tick,
    input logic v_valid,
    input logic v_clean,
    input logic stat_sel,
    input logic low_sig_i,
    input logic lock_o,
    input logic status_o
);

    a_r4_lock_only_at_tick: assert property (@(posedge clk) disable iff (rst)
        (!ref_tick && !restart) |=> $stable(lock_o));

    a_r4_rise_after_clean: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_o) |-> ($past(v_valid) && $past(v_clean)));

    a_r5_bad_period_drops: assert property (@(posedge clk) disable iff (rst)
        (v_valid && !v_clean) |=> !lock_o);

    a_r6_restart_clears: assert property (@(posedge clk) disable iff (rst)
        restart |=> !lock_o);

    a_r8_status_source: assert property (@(posedge clk) disable iff (rst)
        status_o == (stat_sel ? low_sig_i : lock_o));

    a_r9_reset_clears: assert property (@(posedge clk)
        rst |=> !lock_o);

endmodule

bind pll_lock_monitor lock_checker u_lock_chk (
    .clk(clk), .rst(rst), .restart(restart), .ref_tick(ref_tick),
    .v_valid(verdict.valid), .v_clean(verdict.clean),
    .stat_sel(stat_sel), .low_sig_i(low_sig_i),
    .lock_o(lock_o), .status_o(status_o)
);

// File: tb/test_pll_lock_monitor.sv
module test_pll_lock_monitor;

    localparam int NARROW = 2;
    localparam int WIDE   = 4;
    localparam int PLEN   = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic restart = 1'b0;
    logic up_i = 1'b0;
    logic dn_i = 1'b0;
    logic ref_tick = 1'b0;
    logic [1:0] hold_sel = 2'b00;
    logic win_sel = 1'b0;
    logic stat_sel = 1'b0;
    logic low_sig_i = 1'b0;
    logic lock_o;
    logic status_o;

    int total = 0;
    int bad = 0;
    int m_run = 0;
    logic exp_q[$];
    logic tick_seen = 1'b0;
    logic finished = 1'b0;

    always #4 clk = ~clk;

    pll_lock_monitor #(.NARROW_CYC(NARROW), .WIDE_CYC(WIDE)) i_pll_lock_monitor (
        .clk(clk), .rst(rst), .restart(restart), .up_i(up_i), .dn_i(dn_i),
        .ref_tick(ref_tick), .hold_sel(hold_sel), .win_sel(win_sel),
        .stat_sel(stat_sel), .low_sig_i(low_sig_i),
        .lock_o(lock_o), .status_o(status_o)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // One reference period: up-only cycles, then dn-only, then both high, rest idle.
    task automatic period(input int n_up, input int n_dn, input int n_both);
        int mis;
        int need;
        logic exp_lock;
        mis = n_up + n_dn;
        for (int i = 0; i < PLEN; i++) begin
            @(negedge clk);
            up_i = (i < n_up) || (i >= n_up + n_dn && i < mis + n_both);
            dn_i = (i >= n_up && i < mis + n_both);
            ref_tick = (i == PLEN - 1);
            if (i == PLEN - 1) begin
                need = 2 << hold_sel;
                if (mis <= (win_sel ? WIDE : NARROW)) begin
                    m_run = (m_run < 31) ? m_run + 1 : 31;
                    exp_lock = (m_run >= need);
                end else begin
                    m_run = 0;
                    exp_lock = 1'b0;
                end
                exp_q.push_back(exp_lock);
            end
        end
        @(negedge clk);
        up_i = 1'b0; dn_i = 1'b0; ref_tick = 1'b0;
    endtask

    task automatic pulse_restart();
        @(negedge clk);
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
        m_run = 0;
        check(lock_o == 1'b0, "R6 restart clears lock", int'(lock_o), 0);
    endtask

    always @(posedge clk) tick_seen <= ref_tick;

    // Monitor: compare lock after each strobe against the scoreboard.
    always @(negedge clk) begin
        if (tick_seen) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R4 unexpected strobe result", int'(lock_o), -1);
            end else begin
                logic e;
                e = exp_q.pop_front();
                check(lock_o == e, "R4/R5 lock after strobe", int'(lock_o), int'(e));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "watchdog", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(lock_o == 1'b0, "R9 lock low in reset", int'(lock_o), 0);
        check(status_o == 1'b0, "R8 status follows lock in reset", int'(status_o), 0);
        @(negedge clk);
        rst = 1'b0;

        // R3 hold 2, R2 narrow limit boundary, R1 up-only
        hold_sel = 2'b00; win_sel = 1'b0;
        period(0, 0, 0);
        period(1, 0, 0);
        period(2, 0, 0);           // exactly at limit: clean
        check(lock_o == 1'b1, "R4 locked after two clean", int'(lock_o), 1);
        period(3, 0, 0);           // R5 one over the limit
        period(0, 0, 0);           // R5 count restarted: still unlocked
        check(lock_o == 1'b0, "R5 count zeroed by bad period", int'(lock_o), 0);
        period(0, 2, 0);           // R1 dn-only at limit
        period(0, 0, 8);           // R1 both high costs nothing
        check(lock_o == 1'b1, "R1 overlap not counted", int'(lock_o), 1);
        period(1, 1, 0);
        period(2, 1, 4);           // R1 mixed: 3 one-sided cycles -> bad
        check(lock_o == 1'b0, "R1 mixed mismatch bad", int'(lock_o), 0);

        // R2 wide window
        win_sel = 1'b1;
        period(4, 0, 0);
        period(2, 2, 0);
        check(lock_o == 1'b1, "R2 wide limit clean", int'(lock_o), 1);
        period(3, 2, 0);
        check(lock_o == 1'b0, "R2 wide limit exceeded", int'(lock_o), 0);

        // R7: mismatch split over adjacent periods does not add up
        win_sel = 1'b0;
        pulse_restart();
        period(2, 0, 0);
        period(0, 2, 0);
        check(lock_o == 1'b1, "R7 accumulator clears per period", int'(lock_o), 1);

        // R3 every hold setting
        for (int s = 1; s < 4; s++) begin
            pulse_restart();
            hold_sel = 2'(s);
            for (int p = 0; p < (2 << s); p++) period(1, 0, 1);
            check(lock_o == 1'b1, "R3 lock at hold count", int'(lock_o), 1);
        end

        // R6 restart mid-period clears running mismatch too
        hold_sel = 2'b00;
        pulse_restart();
        @(negedge clk); up_i = 1'b1;
        @(negedge clk); @(negedge clk);
        restart = 1'b1;
        @(negedge clk); restart = 1'b0; up_i = 1'b0; m_run = 0;
        period(2, 0, 0);           // would be 4 if carried over
        period(0, 0, 0);
        check(lock_o == 1'b1, "R6 restart clears mismatch count", int'(lock_o), 1);

        // R8 status source
        @(negedge clk);
        stat_sel = 1'b1; low_sig_i = 1'b0;
        #1 check(status_o == 1'b0, "R8 status low flag 0", int'(status_o), 0);
        low_sig_i = 1'b1;
        #1 check(status_o == 1'b1, "R8 status low flag 1", int'(status_o), 1);
        stat_sel = 1'b0; low_sig_i = 1'b0;
        #1 check(status_o == lock_o, "R8 status back to lock", int'(status_o), int'(lock_o));

        // R9 reset while locked
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        check(lock_o == 1'b0, "R9 reset clears lock", int'(lock_o), 0);
        rst = 1'b0;

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule